// File: doc/BRIEF.md
# Clock divider transition sequencer

This block moves a core clock between the divide ratios 1, 2, 4, 6 and 8 and keeps DRAM refresh valid during each move. A requester strobes `start` with a ratio index. The sequencer then drives three controls in a fixed order: the 3-bit divider code, a 7-bit refresh count and a self-refresh enable. The count and the enable sit at fixed positions in a memory control word. Between steps the sequencer waits for PLL lock after every divider write. Where required, it also waits for the old and new refresh counts to drain. `busy` is high until the move completes, and `cur_ratio` reports the ratio now in effect.

Every move is built from legs. A leg is one hop between two ratios, of four kinds:
- **into-one**: 2 to 1.
- **out-of-one**: 1 to 2.
- **slower**: a larger divisor, not involving 1.
- **faster**: a smaller divisor, not ending at 1.

A move between ratio 1 and ratio 4, 6 or 8 is split into two legs through ratio 2.

The state machine has these states: `ST_IDLE`, `ST_SREF_OFF`, `ST_DIV_WR`, `ST_LOCK`, `ST_CNT_WR`, `ST_DRAIN`, `ST_SREF_ON` and `ST_NEXT`. Its transitions are:
- `ST_IDLE` goes to the first state of the leg when a request is accepted. That state is `ST_SREF_OFF` for into-one, `ST_DIV_WR` for faster, and `ST_CNT_WR` for the other two kinds.
- `ST_SREF_OFF` goes to `ST_DIV_WR`.
- `ST_DIV_WR` goes to `ST_LOCK`.
- `ST_LOCK`, once its timer expires, goes to `ST_CNT_WR` (into-one, faster), `ST_SREF_ON` (out-of-one) or `ST_NEXT` (slower).
- `ST_CNT_WR` goes to `ST_DRAIN` (out-of-one or faster with self-refresh off), `ST_DIV_WR` (slower, or out-of-one with self-refresh on) or `ST_NEXT`.
- `ST_DRAIN`, once its timer expires, goes to `ST_DIV_WR` (out-of-one) or `ST_NEXT`.
- `ST_SREF_ON` goes to `ST_NEXT`.
- `ST_NEXT` starts the second leg if the target is not yet reached, and otherwise returns to `ST_IDLE`.

Top module: `clkdiv_seq`

## Requirements
- R1: After reset the divider code is 3'b000 (ratio 1), self-refresh is off, the refresh count equals `base_cnt`, `busy` is low and `cur_ratio` is 1.
- R2: Indices 0, 1, 2, 3 and 4 select ratios 1, 2, 4, 6 and 8. These ratios drive the divider codes 3'b000, 3'b001, 3'b011, 3'b010 and 3'b100 respectively.
- R3: After a move to index i, the refresh count field (bits 14:8 of `mem_ctl`) equals floor(`base_cnt` / ratio(i)).
- R4: In a 2-to-1 leg the changes come in this order: self-refresh enable (bit 16 of `mem_ctl`) clears, then the divider code changes, then the refresh count changes.
- R5: In a 1-to-2 leg the refresh count changes first, then the divider code, then self-refresh enable sets.
- R6: In any other leg to a larger divisor, the refresh count changes before the divider code. In any other leg to a smaller divisor, the divider code changes before the refresh count.
- R7: A move between ratio 1 and ratio 4, 6 or 8, in either direction, passes through ratio 2 as two legs.
- R8: After a divider code change, no other output changes for at least `PLL_LOCK_CYC` cycles.
- R9: In a 1-to-2 leg, or a leg to a smaller divisor, a count change made while self-refresh is off is followed by a wait. No further output change comes for at least `CLKS_PER_CNT` × (old count + new count) × old ratio cycles.
- R10: A request for the index already in effect changes no output and leaves `busy` low.
- R11: A request with index 5, 6 or 7 while idle is ignored and raises `req_err` for one cycle.
- R12: A `start` strobe while `busy` is high is ignored: the running move completes to its own target and `req_err` stays low.
- R13: `busy` rises the cycle after an accepted strobe and stays high until the last step. Outputs change only while `busy` is high, and `cur_ratio` shows the target once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, one cycle |
| req_idx | input | 3 | Requested ratio index |
| base_cnt | input | 7 | Refresh count for ratio 1 |
| div_code | output | 3 | Divider code to the clock generator |
| mem_ctl | output | 17 | Memory control word: count in 14:8, self-refresh enable in 16, other bits zero |
| busy | output | 1 | Move in progress |
| req_err | output | 1 | One-cycle pulse on a rejected index |
| cur_ratio | output | 4 | Ratio now in effect (1, 2, 4, 6 or 8) |

## Verification
The bench builds the block with `PLL_LOCK_CYC` = 16 and `CLKS_PER_CNT` = 2. The drain wait of an out-of-one leg is therefore a few hundred cycles rather than tens of thousands. This lets many moves run, each with its drain, in one short run. Base counts of 96 and then 127 give five distinct refresh counts per base. Every count write is therefore visible at the port, including the divide-by-6 floor. The bench also checks the order and spacing of every change against its own model of the legs.

// File: rtl/clkdiv_seq_pkg.sv
`timescale 1ns/1ps
package clkdiv_seq_pkg;

    localparam int CNT_W     = 7;
    localparam int CNT_LSB   = 8;
    localparam int SREF_BIT  = 16;
    localparam int CTL_W     = SREF_BIT + 1;
    localparam int IDX_W     = 3;
    localparam int MAX_IDX   = 4;
    localparam int RATIO_W   = 4;

    typedef enum logic [1:0] {
        LEG_INTO_ONE,
        LEG_OUT_OF_ONE,
        LEG_SLOWER,
        LEG_FASTER
    } leg_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SREF_OFF,
        ST_DIV_WR,
        ST_LOCK,
        ST_CNT_WR,
        ST_DRAIN,
        ST_SREF_ON,
        ST_NEXT
    } seq_state_t;

    function automatic logic [2:0] div_code_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] scaled_count(input logic [CNT_W-1:0] base,
                                                      input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return base;
            3'd1:    return base >> 1;
            3'd2:    return base >> 2;
            3'd3:    return base / 7'd6;
            default: return base >> 3;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_leg_plan.sv
`timescale 1ns/1ps
module clkdiv_leg_plan
    import clkdiv_seq_pkg::*;
(
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    output leg_kind_t        kind,
    output logic [IDX_W-1:0] hop_idx
);
    always_comb begin
        hop_idx = dst_idx;
        kind    = LEG_FASTER;
        if (src_idx == 3'd0 && dst_idx >= 3'd2) begin
            hop_idx = 3'd1;
            kind    = LEG_OUT_OF_ONE;
        end else if (src_idx >= 3'd2 && dst_idx == 3'd0) begin
            hop_idx = 3'd1;
            kind    = LEG_FASTER;
        end else if (src_idx == 3'd1 && dst_idx == 3'd0) begin
            kind    = LEG_INTO_ONE;
        end else if (src_idx == 3'd0 && dst_idx == 3'd1) begin
            kind    = LEG_OUT_OF_ONE;
        end else if (src_idx < dst_idx) begin
            kind    = LEG_SLOWER;
        end
    end
endmodule

// File: rtl/clkdiv_wait_timer.sv
`timescale 1ns/1ps
module clkdiv_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
    import clkdiv_seq_pkg::*;
#(
    parameter int PLL_LOCK_CYC = 16,
    parameter int CLKS_PER_CNT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [CNT_W-1:0]   base_cnt,
    output logic [2:0]         div_code,
    output logic [CTL_W-1:0]   mem_ctl,
    output logic               busy,
    output logic               req_err,
    output logic [RATIO_W-1:0] cur_ratio
);
    localparam int DRAIN_MAX = CLKS_PER_CNT * 2 * ((1 << CNT_W) - 1) * 8;
    localparam int TMR_MAX   = (DRAIN_MAX > PLL_LOCK_CYC) ? DRAIN_MAX : PLL_LOCK_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    seq_state_t       state_q, state_d;
    leg_kind_t        kind_q, plan_kind;
    logic [IDX_W-1:0] cur_idx_q, src_idx_q, hop_idx_q, dst_idx_q;
    logic [IDX_W-1:0] plan_dst, plan_hop;
    logic [2:0]       div_q;
    logic [CNT_W-1:0] cnt_q, new_cnt;
    logic             sref_q, err_q;
    logic             accept, bad_req, leg_go;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val, drain_len;

    assign plan_dst = (state_q == ST_IDLE) ? req_idx : dst_idx_q;

    clkdiv_leg_plan u_plan (
        .src_idx (cur_idx_q),
        .dst_idx (plan_dst),
        .kind    (plan_kind),
        .hop_idx (plan_hop)
    );

    assign accept  = (state_q == ST_IDLE) && start &&
                     (req_idx <= IDX_W'(MAX_IDX)) && (req_idx != cur_idx_q);
    assign bad_req = (state_q == ST_IDLE) && start && (req_idx > IDX_W'(MAX_IDX));
    assign leg_go  = accept || ((state_q == ST_NEXT) && (cur_idx_q != dst_idx_q));

    assign new_cnt   = scaled_count(base_cnt, hop_idx_q);
    assign drain_len = TMR_W'(CLKS_PER_CNT) *
                       (TMR_W'(cnt_q) + TMR_W'(new_cnt)) *
                       TMR_W'(ratio_of(src_idx_q));

    assign tmr_load = (state_q == ST_DIV_WR) ||
                      ((state_q == ST_CNT_WR) && (state_d == ST_DRAIN));
    assign tmr_val  = (state_q == ST_DIV_WR) ? TMR_W'(PLL_LOCK_CYC) : drain_len;

    clkdiv_wait_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    function automatic seq_state_t leg_entry(input leg_kind_t k);
        case (k)
            LEG_INTO_ONE: return ST_SREF_OFF;
            LEG_FASTER:   return ST_DIV_WR;
            default:      return ST_CNT_WR;
        endcase
    endfunction

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = leg_entry(plan_kind);
            ST_SREF_OFF: state_d = ST_DIV_WR;
            ST_DIV_WR:   state_d = ST_LOCK;
            ST_LOCK: begin
                if (tmr_expired) begin
                    case (kind_q)
                        LEG_INTO_ONE, LEG_FASTER: state_d = ST_CNT_WR;
                        LEG_OUT_OF_ONE:           state_d = ST_SREF_ON;
                        default:                  state_d = ST_NEXT;
                    endcase
                end
            end
            ST_CNT_WR: begin
                case (kind_q)
                    LEG_OUT_OF_ONE: state_d = sref_q ? ST_DIV_WR : ST_DRAIN;
                    LEG_FASTER:     state_d = sref_q ? ST_NEXT   : ST_DRAIN;
                    LEG_SLOWER:     state_d = ST_DIV_WR;
                    default:        state_d = ST_NEXT;
                endcase
            end
            ST_DRAIN: begin
                if (tmr_expired)
                    state_d = (kind_q == LEG_OUT_OF_ONE) ? ST_DIV_WR : ST_NEXT;
            end
            ST_SREF_ON:  state_d = ST_NEXT;
            ST_NEXT:     state_d = leg_go ? leg_entry(plan_kind) : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and leg registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= 3'b000;
            cnt_q     <= base_cnt;
            sref_q    <= 1'b0;
            err_q     <= 1'b0;
            cur_idx_q <= '0;
            src_idx_q <= '0;
            hop_idx_q <= '0;
            dst_idx_q <= '0;
            kind_q    <= LEG_SLOWER;
        end else begin
            err_q <= bad_req;
            if (accept) dst_idx_q <= req_idx;
            if (leg_go) begin
                src_idx_q <= cur_idx_q;
                hop_idx_q <= plan_hop;
                kind_q    <= plan_kind;
            end
            case (state_q)
                ST_SREF_OFF: sref_q <= 1'b0;
                ST_DIV_WR: begin
                    div_q     <= div_code_of(hop_idx_q);
                    cur_idx_q <= hop_idx_q;
                end
                ST_CNT_WR:   cnt_q  <= new_cnt;
                ST_SREF_ON:  sref_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign div_code  = div_q;
    assign mem_ctl   = {sref_q, 1'b0, cnt_q, {CNT_LSB{1'b0}}};
    assign busy      = (state_q != ST_IDLE);
    assign req_err   = err_q;
    assign cur_ratio = ratio_of(cur_idx_q);
endmodule

// File: rtl/clkdiv_seq_chk.sv
`timescale 1ns/1ps
module clkdiv_seq_chk #(
    parameter int PLL_LOCK_CYC = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  div_code,
    input logic [16:0] mem_ctl,
    input logic        busy,
    input logic        req_err,
    input logic [3:0]  cur_ratio
);
    logic [2:0]  div_prev;
    logic [16:0] ctl_prev;
    logic [15:0] gap;

    always_ff @(posedge clk) begin
        div_prev <= div_code;
        ctl_prev <= mem_ctl;
        if (!rst_n)                    gap <= '1;
        else if (div_code != div_prev) gap <= 16'd1;
        else if (gap != '1)            gap <= gap + 16'd1;
    end

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_code <= 3'd4);

    p_ratio_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio == 4'd1) == (div_code == 3'b000) &&
        (cur_ratio == 4'd6) == (div_code == 3'b010) &&
        (cur_ratio == 4'd8) == (div_code == 3'b100));

    p_pll_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ctl != ctl_prev) |-> (gap >= 16'(PLL_LOCK_CYC)));

    p_err_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!busy && $past(start)));

    p_busy_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !req_err);

    p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(div_code) && $stable(mem_ctl)));
endmodule

bind clkdiv_seq clkdiv_seq_chk #(.PLL_LOCK_CYC(PLL_LOCK_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .div_code  (div_code),
    .mem_ctl   (mem_ctl),
    .busy      (busy),
    .req_err   (req_err),
    .cur_ratio (cur_ratio)
);

// File: tb/clkdiv_seq_bench.sv
`timescale 1ns/1ps
module clkdiv_seq_bench;
    localparam int PLL  = 16;
    localparam int CPC  = 2;
    localparam int E_DIV = 0, E_CNT = 1, E_SREF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [6:0]  base_cnt = 7'd96;
    logic [2:0]  div_code;
    logic [16:0] mem_ctl;
    logic        busy, req_err;
    logic [3:0]  cur_ratio;

    clkdiv_seq #(.PLL_LOCK_CYC(PLL), .CLKS_PER_CNT(CPC)) u_clkdiv_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_idx(req_idx),
        .base_cnt(base_cnt), .div_code(div_code), .mem_ctl(mem_ctl),
        .busy(busy), .req_err(req_err), .cur_ratio(cur_ratio)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int ev_type[32], ev_time[32], ev_n = 0;
    int ex_type[32], ex_gap[32], ex_n = 0;
    string ex_tag[32];
    int model_idx = 0, model_cnt = 96;
    logic [2:0] p_div; logic [6:0] p_cnt; logic p_sref;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R13: watchdog actual %0d expected 0", cyc);
            report();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (div_code != p_div && ev_n < 32)        begin ev_type[ev_n] = E_DIV;  ev_time[ev_n] = cyc; ev_n++; end
            if (mem_ctl[14:8] != p_cnt && ev_n < 32)   begin ev_type[ev_n] = E_CNT;  ev_time[ev_n] = cyc; ev_n++; end
            if (mem_ctl[16] != p_sref && ev_n < 32)    begin ev_type[ev_n] = E_SREF; ev_time[ev_n] = cyc; ev_n++; end
        end
        p_div = div_code; p_cnt = mem_ctl[14:8]; p_sref = mem_ctl[16];
    end

    function automatic int code_of(int i);
        case (i) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
    endfunction
    function automatic int rat(int i);
        case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
    endfunction
    function automatic int cnt_of(int b, int i);
        return b / rat(i);
    endfunction

    task automatic add_ev(input int t, input int g, input string tag);
        ex_type[ex_n] = t; ex_gap[ex_n] = g; ex_tag[ex_n] = tag; ex_n++;
    endtask

    task automatic plan_leg(input int a, input int b, input string tg);
        int nc;
        nc = cnt_of(int'(base_cnt), b);
        if (a == 1 && b == 0) begin
            add_ev(E_SREF, 0, "R4"); add_ev(E_DIV, PLL, "R4"); add_ev(E_CNT, 0, "R4");
        end else if (a == 0 && b == 1) begin
            add_ev(E_CNT, CPC * (model_cnt + nc), "R5");
            add_ev(E_DIV, PLL, "R5"); add_ev(E_SREF, 0, "R5");
        end else if (a < b) begin
            add_ev(E_CNT, 0, tg); add_ev(E_DIV, PLL, tg);
        end else begin
            add_ev(E_DIV, PLL, tg); add_ev(E_CNT, 0, tg);
        end
        model_cnt = nc;
    endtask

    task automatic do_move(input int idx, input bit poke, input int poke_idx);
        int guard;
        string tg;
        ex_n = 0;
        tg = "R6";
        if (model_idx == 0 && idx >= 2) begin
            tg = "R7"; plan_leg(0, 1, tg); plan_leg(1, idx, tg);
        end else if (model_idx >= 2 && idx == 0) begin
            tg = "R7"; plan_leg(model_idx, 1, tg); plan_leg(1, 0, tg);
        end else plan_leg(model_idx, idx, tg);
        @(negedge clk); #1;
        ev_n = 0; start = 1'b1; req_idx = 3'(idx);
        @(negedge clk); #1;
        start = 1'b0;
        chk(busy === 1'b1, "R13 busy rises", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            #1; start = 1'b1; req_idx = 3'(poke_idx);
            @(negedge clk); #1; start = 1'b0;
            chk(req_err === 1'b0, "R12 no error while busy", int'(req_err), 0);
        end
        guard = 0;
        while (busy && guard < 20000) begin @(negedge clk); #1; guard++; end
        chk(ev_n == ex_n, {tg, " change count"}, ev_n, ex_n);
        for (int i = 0; i < ex_n && i < ev_n; i++) begin
            chk(ev_type[i] == ex_type[i], {ex_tag[i], " change order"}, ev_type[i], ex_type[i]);
            if (i + 1 < ev_n && ex_gap[i] > 0) begin
                if (ex_type[i] == E_DIV)
                    chk(ev_time[i+1] - ev_time[i] >= ex_gap[i], "R8 lock gap", ev_time[i+1] - ev_time[i], ex_gap[i]);
                else begin
                    chk(ev_time[i+1] - ev_time[i] >= ex_gap[i], "R9 drain gap", ev_time[i+1] - ev_time[i], ex_gap[i]);
                    chk(ev_time[i+1] - ev_time[i] <= ex_gap[i] + 8, "R9 drain bound", ev_time[i+1] - ev_time[i], ex_gap[i]);
                end
            end
        end
        model_idx = idx;
        chk(int'(div_code) == code_of(idx), "R2 divider code", int'(div_code), code_of(idx));
        chk(int'(mem_ctl[14:8]) == cnt_of(int'(base_cnt), idx), "R3 refresh count", int'(mem_ctl[14:8]), cnt_of(int'(base_cnt), idx));
        chk(mem_ctl[16] == (idx != 0), "R5 self-refresh state", int'(mem_ctl[16]), int'(idx != 0));
        chk(int'(cur_ratio) == rat(idx), "R13 cur_ratio", int'(cur_ratio), rat(idx));
    endtask

    task automatic same_req;
        @(negedge clk); #1;
        ev_n = 0; start = 1'b1; req_idx = 3'(model_idx);
        @(negedge clk); #1; start = 1'b0;
        chk(busy === 1'b0, "R10 busy stays low", int'(busy), 0);
        repeat (20) @(negedge clk);
        #1;
        chk(ev_n == 0, "R10 no output change", ev_n, 0);
    endtask

    task automatic bad_req(input int idx);
        @(negedge clk); #1;
        ev_n = 0; start = 1'b1; req_idx = 3'(idx);
        @(negedge clk); #1; start = 1'b0;
        chk(req_err === 1'b1, "R11 error pulse", int'(req_err), 1);
        chk(busy === 1'b0, "R11 not busy", int'(busy), 0);
        @(negedge clk); #1;
        chk(req_err === 1'b0, "R11 pulse one cycle", int'(req_err), 0);
        repeat (5) @(negedge clk);
        #1;
        chk(ev_n == 0, "R11 outputs unchanged", ev_n, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk); #1;
        chk(div_code == 3'b000, "R1 divider code", int'(div_code), 0);
        chk(mem_ctl[16] == 1'b0, "R1 self-refresh", int'(mem_ctl[16]), 0);
        chk(int'(mem_ctl[14:8]) == 96, "R1 refresh count", int'(mem_ctl[14:8]), 96);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(cur_ratio == 4'd1, "R1 ratio", int'(cur_ratio), 1);

        do_move(1, 0, 0);   // R5
        do_move(0, 0, 0);   // R4
        do_move(2, 0, 0);   // R7 up
        do_move(3, 0, 0);   // R6 slower
        do_move(4, 0, 0);
        do_move(1, 0, 0);   // R6 faster
        do_move(4, 0, 0);
        do_move(0, 0, 0);   // R7 down
        same_req();
        bad_req(5);
        bad_req(7);
        do_move(3, 1, 7);   // R12 poke with bad index
        do_move(0, 1, 2);   // R12 poke with valid index
        same_req();

        @(negedge clk); #1; base_cnt = 7'd127;
        for (int k = 0; k < 25; k++) begin
            int t;
            t = int'($urandom_range(4, 0));
            if (t == model_idx) same_req();
            else do_move(t, 0, 0);
        end
        do_move(0, 0, 0);
        bad_req(6);

        report();
        $finish;
    end
endmodule